// File: doc/BRIEF.md
# Card Command Issue and Response Check

This block sits between a host's register write port and a memory card link. Software writes a 16-bit command word. The block splits that word into its fields and starts the command with a one-cycle launch pulse, which carries the command index and a 32-bit argument. The argument is assembled earlier from two 16-bit writes, one for each half. A command word also tells the block whether a data transfer follows. If it does, the block flushes the data buffer and records the direction.

After a launch the block waits for the response. The link layer returns it as one valid beat that carries a received byte count and a response image of up to sixteen bytes. The block checks the count against the length the response type requires. It then sets the command-end or timeout status and examines the card status word for error bits. It also fills eight 16-bit response words in a fixed big-end-first byte-pair order. CRC and line timing belong to the link layer.

Top module: `sd_cmd_issue`

## Requirements
- R1: Command word fields are: index in bits 5:0, init in bit 7, response type in bits 10:8, busy in bit 11, command kind in bits 13:12, data direction in bit 15. A command write (reg_sel_i = 0) accepted while idle raises cmd_valid_o for exactly one cycle, starting the cycle after the write, with cmd_index_o set to the index and cmd_arg_o set to the argument.
- R2: A command write is ignored while enable_i is low, and also while a response is still awaited. It causes no launch and leaves status and the response words unchanged.
- R3: An accepted command write with init = 1 and index 0 sets the status to exactly bit 0, launches nothing, waits for no response and leaves the transfer state unchanged.
- R4: An accepted, launched command of kind 3 pulses buf_flush_o for one cycle, sets xfer_active_o and latches bit 15 into xfer_dir_o. A launched command of any other kind clears xfer_active_o.
- R5: Response type 2 (long) needs rsp_len_i >= 16. Types 1, 3 and 6 (short) need rsp_len_i >= 4. A shorter response sets status bit 7 (timeout) and not bit 0. Type 0 and the unused codes 4, 5 and 7 never time out.
- R6: A response that does not time out sets status bit 0. It sets bits 0 and 2 together when the command index is 12.
- R7: For type 1, with or without busy, bytes 0..3 form a big-endian status word. If that word has any bit set in mask 0xFDF90000, status bit 14 is set. The mask also includes bit 3 only when ake_en_i is high.
- R8: For type 6, bytes 2 (high) and 3 (low) form a 16-bit word. If that word has any bit set in mask 0xE008, status bit 14 is set.
- R9: For type 3, status bit 12 is set when bit 31 of the big-endian word in bytes 0..3 (byte 0, bit 7) is clear.
- R10: An accepted command write zeroes all eight response words. A response of type 1, 2, 3 or 6 that does not time out loads word k with byte 2(7-k) in bits 15:8 and byte 2(7-k)+1 in bits 7:0. Byte j of rsp_data_i is bits 8j+7:8j. Timed-out responses and types 0, 4, 5 and 7 leave the words at zero.
- R11: A write with reg_sel_i = 1 replaces argument bits 15:0, and a write with reg_sel_i = 2 replaces bits 31:16. Each keeps the other half. reg_sel_i = 3 has no effect.
- R12: An accepted command write clears every status bit before the response is evaluated. Only bits 0, 2, 7, 12 and 14 are ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable; command writes need it high |
| ake_en_i | input | 1 | Adds the AKE sequence error bit to the card error mask |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | 0 command, 1 argument low, 2 argument high |
| reg_wdata_i | input | 16 | Write data |
| cmd_valid_o | output | 1 | One-cycle launch pulse |
| cmd_index_o | output | 6 | Launched command index |
| cmd_arg_o | output | 32 | Launched argument |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_len_i | input | 5 | Received response byte count |
| rsp_data_i | input | 128 | Response image, byte j at bits 8j+7:8j |
| status_o | output | 16 | Command status bits |
| rsp_words_o | output | 128 | Response word k at bits 16k+15:16k |
| xfer_active_o | output | 1 | Data transfer in progress |
| xfer_dir_o | output | 1 | Latched data direction |
| buf_flush_o | output | 1 | One-cycle data buffer reset pulse |

## Verification
On every cycle, the assertions check that a launch lasts one cycle and that an ignored command write never launches. They also check that timeout and command end never appear together, that the stop bit only appears with command end, and that a flush always comes with an active transfer. Further cycle checks cover the response-word clear on each accepted command and the preservation of the argument's other half. The values themselves can only be shown by the bench's directed scenarios: the length thresholds for each response type, the card error masks with and without the AKE bit, the OCR busy test, the RCA error field and the exact byte-pair order of the response words.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int CMD_W   = 16;
  localparam int IDX_W   = 6;
  localparam int STAT_W  = 16;
  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = 16;

  // status bit positions
  localparam int ST_END  = 0;
  localparam int ST_STOP = 2;
  localparam int ST_TMO  = 7;
  localparam int ST_OCR  = 12;
  localparam int ST_CERR = 14;

  localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;
  localparam logic [1:0]       KIND_DATA = 2'd3;

  localparam logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000;
  localparam logic [31:0] AKE_ERR_BIT   = 32'h0000_0008;
  localparam logic [15:0] RCA_ERR_MASK  = 16'hE008;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_ARG_LO = 2'd1,
    SEL_ARG_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SHORT,
    RK_SHORT_BUSY,
    RK_LONG,
    RK_OCR,
    RK_RCA
  } rsp_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             init;
    rsp_kind_e        kind;
    logic [1:0]       ckind;
    logic             dir;
  } cmd_fields_t;

endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sd_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_fields_t      fields_o,
  output logic             skip_bus_o
);
  logic [2:0] rtype;
  logic       busy;
  logic       unused_bits;

  assign rtype       = word_i[10:8];
  assign busy        = word_i[11];
  assign unused_bits = ^{word_i[14], word_i[6]};

  always_comb begin
    fields_o.idx   = word_i[5:0];
    fields_o.init  = word_i[7];
    fields_o.ckind = word_i[13:12];
    fields_o.dir   = word_i[15];
    unique case (rtype)
      3'd1:    fields_o.kind = busy ? RK_SHORT_BUSY : RK_SHORT;
      3'd2:    fields_o.kind = RK_LONG;
      3'd3:    fields_o.kind = RK_OCR;
      3'd6:    fields_o.kind = RK_RCA;
      default: fields_o.kind = RK_NONE;
    endcase
  end

  assign skip_bus_o = word_i[7] && (word_i[5:0] == '0);

endmodule

// File: rtl/sd_rsp_check.sv
module sd_rsp_check
  import sd_cmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  localparam int LEN_W = $clog2(RSP_BYTES + 1)
) (
  input  rsp_kind_e            kind_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 ake_en_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [8*RSP_BYTES-1:0] data_i,
  output logic [STAT_W-1:0]    set_o,
  output logic                 load_o
);
  logic        is_short, is_long, tmo;
  logic [31:0] card_word, err_mask;
  logic [15:0] rca_word;

  assign card_word = {data_i[7:0], data_i[15:8], data_i[23:16], data_i[31:24]};
  assign rca_word  = {data_i[23:16], data_i[31:24]};
  assign err_mask  = CARD_ERR_MASK | (ake_en_i ? AKE_ERR_BIT : 32'h0);

  assign is_short = (kind_i == RK_SHORT) || (kind_i == RK_SHORT_BUSY) ||
                    (kind_i == RK_OCR)   || (kind_i == RK_RCA);
  assign is_long  = (kind_i == RK_LONG);

  always_comb begin
    tmo = 1'b0;
    if (is_long  && (len_i < LEN_W'(LONG_LEN)))  tmo = 1'b1;
    if (is_short && (len_i < LEN_W'(SHORT_LEN))) tmo = 1'b1;
  end

  assign load_o = (is_short || is_long) && !tmo;

  always_comb begin
    set_o = '0;
    if (tmo) begin
      set_o[ST_TMO] = 1'b1;
    end else begin
      set_o[ST_END]  = 1'b1;
      set_o[ST_STOP] = (idx_i == STOP_IDX);
      unique case (kind_i)
        RK_SHORT, RK_SHORT_BUSY: set_o[ST_CERR] = |(card_word & err_mask);
        RK_RCA:                  set_o[ST_CERR] = |(rca_word & RCA_ERR_MASK);
        RK_OCR:                  set_o[ST_OCR]  = !card_word[31];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sd_rsp_bank.sv
module sd_rsp_bank #(
  parameter int RSP_BYTES = 16,
  parameter int WORD_W    = 16,
  localparam int NUM_WORDS = RSP_BYTES * 8 / WORD_W,
  localparam int BPW       = WORD_W / 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         load_i,
  input  logic [8*RSP_BYTES-1:0]       img_i,
  output logic [NUM_WORDS*WORD_W-1:0]  words_o
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] nxt, q;
    // earliest byte of the pair lands in the top byte
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      assign nxt[WORD_W-1-8*b -: 8] = img_i[8*(BPW*(NUM_WORDS-1-k)+b) +: 8];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (clr_i)   q <= '0;
      else if (load_i)  q <= nxt;
    end
    assign words_o[k*WORD_W +: WORD_W] = q;
  end

  // R10
  words_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (words_o == '0));

endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int WORD_W    = 16,
  localparam int NUM_WORDS = RSP_BYTES * 8 / WORD_W,
  localparam int LEN_W     = $clog2(RSP_BYTES + 1),
  localparam int ARG_W     = 2 * WORD_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        enable_i,
  input  logic                        ake_en_i,
  input  logic                        reg_we_i,
  input  logic [1:0]                  reg_sel_i,
  input  logic [WORD_W-1:0]           reg_wdata_i,
  output logic                        cmd_valid_o,
  output logic [IDX_W-1:0]            cmd_index_o,
  output logic [ARG_W-1:0]            cmd_arg_o,
  input  logic                        rsp_valid_i,
  input  logic [LEN_W-1:0]            rsp_len_i,
  input  logic [8*RSP_BYTES-1:0]      rsp_data_i,
  output logic [STAT_W-1:0]           status_o,
  output logic [NUM_WORDS*WORD_W-1:0] rsp_words_o,
  output logic                        xfer_active_o,
  output logic                        xfer_dir_o,
  output logic                        buf_flush_o
);
  cmd_fields_t        dec;
  logic               skip_bus;
  logic               acc, launch, eval;
  logic               waiting_q;
  rsp_kind_e          kind_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ARG_W-1:0]   arg_q;
  logic [STAT_W-1:0]  set_bits;
  logic               load_ok;

  sd_cmd_decode u_dec (
    .word_i     (reg_wdata_i[CMD_W-1:0]),
    .fields_o   (dec),
    .skip_bus_o (skip_bus)
  );

  assign acc    = reg_we_i && (reg_sel_i == SEL_CMD) && enable_i && !waiting_q;
  assign launch = acc && !skip_bus;
  assign eval   = waiting_q && rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q <= '0;
    end else if (reg_we_i && (reg_sel_i == SEL_ARG_LO)) begin
      arg_q[WORD_W-1:0] <= reg_wdata_i;
    end else if (reg_we_i && (reg_sel_i == SEL_ARG_HI)) begin
      arg_q[ARG_W-1:WORD_W] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q     <= 1'b0;
      cmd_valid_o   <= 1'b0;
      cmd_index_o   <= '0;
      cmd_arg_o     <= '0;
      kind_q        <= RK_NONE;
      idx_q         <= '0;
      buf_flush_o   <= 1'b0;
      xfer_active_o <= 1'b0;
      xfer_dir_o    <= 1'b0;
    end else begin
      cmd_valid_o <= launch;
      buf_flush_o <= launch && (dec.ckind == KIND_DATA);
      if (launch) begin
        waiting_q   <= 1'b1;
        cmd_index_o <= dec.idx;
        cmd_arg_o   <= arg_q;
        kind_q      <= dec.kind;
        idx_q       <= dec.idx;
        if (dec.ckind == KIND_DATA) begin
          xfer_active_o <= 1'b1;
          xfer_dir_o    <= dec.dir;
        end else begin
          xfer_active_o <= 1'b0;
        end
      end else if (eval) begin
        waiting_q <= 1'b0;
      end
    end
  end

  sd_rsp_check #(.RSP_BYTES(RSP_BYTES)) u_chk (
    .kind_i   (kind_q),
    .idx_i    (idx_q),
    .ake_en_i (ake_en_i),
    .len_i    (rsp_len_i),
    .data_i   (rsp_data_i),
    .set_o    (set_bits),
    .load_o   (load_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   status_o <= '0;
    else if (acc)  status_o <= skip_bus ? STAT_W'(1) << ST_END : '0;
    else if (eval) status_o <= status_o | set_bits;
  end

  sd_rsp_bank #(.RSP_BYTES(RSP_BYTES), .WORD_W(WORD_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc),
    .load_i  (eval && load_ok),
    .img_i   (rsp_data_i),
    .words_o (rsp_words_o)
  );

  // R2
  cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (reg_sel_i == SEL_CMD) && (!enable_i || waiting_q)) |=> !cmd_valid_o);
  // R1
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  // R5
  end_tmo_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[ST_TMO] && status_o[ST_END]));
  // R6
  stop_with_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_STOP] |-> status_o[ST_END]);
  // R4
  flush_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_flush_o |-> xfer_active_o);
  // R3
  init_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && skip_bus) |=> (!cmd_valid_o && !waiting_q && status_o == STAT_W'(1)));
  // R11
  arg_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_ARG_HI) |=> (arg_q[WORD_W-1:0] == $past(arg_q[WORD_W-1:0])));
  // R12
  status_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~16'h5085) == '0);

endmodule

// File: tb/sd_cmd_issue_tb_top.sv
module sd_cmd_issue_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         enable_i = 1'b0;
  logic         ake_en_i = 1'b0;
  logic         reg_we_i = 1'b0;
  logic [1:0]   reg_sel_i = 2'd0;
  logic [15:0]  reg_wdata_i = '0;
  logic         cmd_valid_o;
  logic [5:0]   cmd_index_o;
  logic [31:0]  cmd_arg_o;
  logic         rsp_valid_i = 1'b0;
  logic [4:0]   rsp_len_i = '0;
  logic [127:0] rsp_data_i = '0;
  logic [15:0]  status_o;
  logic [127:0] rsp_words_o;
  logic         xfer_active_o, xfer_dir_o, buf_flush_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sd_cmd_issue dut_i (
    .clk_i, .rst_ni, .enable_i, .ake_en_i, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .cmd_valid_o, .cmd_index_o, .cmd_arg_o, .rsp_valid_i, .rsp_len_i, .rsp_data_i,
    .status_o, .rsp_words_o, .xfer_active_o, .xfer_dir_o, .buf_flush_o
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input int idx, input int rtype, input bit busy,
                                      input int ckind, input bit dir, input bit init);
    return {dir, 1'b0, 2'(ckind), busy, 3'(rtype), init, 1'b0, 6'(idx)};
  endfunction

  function automatic logic [127:0] mk_img(input logic [31:0] head, input logic [7:0] seed);
    logic [127:0] img;
    img = '0;
    for (int j = 0; j < 4; j++) img[8*j +: 8] = head[31-8*j -: 8];
    for (int j = 4; j < 16; j++) img[8*j +: 8] = seed + 8'(j);
    return img;
  endfunction

  function automatic logic [127:0] exp_words(input logic [127:0] img);
    logic [127:0] w;
    for (int k = 0; k < 8; k++)
      w[16*k +: 16] = {img[8*(2*(7-k)) +: 8], img[8*(2*(7-k)+1) +: 8]};
    return w;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic respond(input int len, input logic [127:0] img);
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_len_i = 5'(len); rsp_data_i = img;
    @(negedge clk_i);
    rsp_valid_i = 1'b0;
  endtask

  // launch a command and answer it, then check status and words
  task automatic run_cmd(input string tag, input logic [15:0] word, input int len,
                         input logic [127:0] img, input logic [15:0] exp_stat,
                         input logic [127:0] exp_w);
    wr(2'd0, word);
    chk({tag, " launch"}, 128'(cmd_valid_o), 128'(1));
    respond(len, img);
    chk({tag, " status"}, 128'(status_o), 128'(exp_stat));
    chk({tag, " words"}, rsp_words_o, exp_w);
  endtask

  task automatic t_reset();
    chk("R12 reset status", 128'(status_o), 0);
    chk("R1 reset launch", 128'(cmd_valid_o), 0);
    chk("R10 reset words", rsp_words_o, 0);
    chk("R4 reset xfer", 128'(xfer_active_o), 0);
  endtask

  task automatic t_arg_and_launch();
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'hABCD);
    wr(2'd1, 16'h5678);
    wr(2'd3, 16'hFFFF); // R11 unused select
    wr(2'd0, cw(17, 1, 0, 2, 0, 0));
    chk("R1 pulse", 128'(cmd_valid_o), 1);
    chk("R1 index", 128'(cmd_index_o), 17);
    chk("R11 argument", 128'(cmd_arg_o), 128'(32'hABCD5678));
    @(negedge clk_i);
    chk("R1 pulse ends", 128'(cmd_valid_o), 0);
    respond(4, mk_img(32'h0000_0900, 8'h10));
    chk("R6 end", 128'(status_o), 128'(16'h0001));
    chk("R10 short load", rsp_words_o, exp_words(mk_img(32'h0000_0900, 8'h10)));
  endtask

  task automatic t_disabled();
    logic [127:0] w0;
    w0 = rsp_words_o;
    enable_i = 1'b0;
    wr(2'd0, cw(5, 1, 0, 2, 0, 0));
    chk("R2 disabled no launch", 128'(cmd_valid_o), 0);
    chk("R2 disabled status kept", 128'(status_o), 128'(16'h0001));
    chk("R2 disabled words kept", rsp_words_o, w0);
    enable_i = 1'b1;
  endtask

  task automatic t_pending();
    wr(2'd0, cw(7, 1, 0, 2, 0, 0));
    chk("R12 cleared on accept", 128'(status_o), 0);
    chk("R10 zeroed on accept", rsp_words_o, 0);
    wr(2'd0, cw(9, 1, 0, 2, 0, 0));
    chk("R2 pending no launch", 128'(cmd_valid_o), 0);
    respond(4, mk_img(32'h0, 8'h20));
    chk("R2 pending first cmd ends", 128'(status_o), 128'(16'h0001));
  endtask

  task automatic t_card_err();
    logic [127:0] img;
    img = mk_img(32'h8000_0000, 8'h30);
    run_cmd("R7 busy err", cw(13, 1, 1, 2, 0, 0), 4, img, 16'h4001, exp_words(img));
    img = mk_img(32'h0002_0000, 8'h31);
    run_cmd("R7 bit17 not in mask", cw(13, 1, 0, 2, 0, 0), 4, img, 16'h0001, exp_words(img));
    img = mk_img(32'h0000_0008, 8'h32);
    ake_en_i = 1'b0;
    run_cmd("R7 ake off", cw(13, 1, 0, 2, 0, 0), 4, img, 16'h0001, exp_words(img));
    ake_en_i = 1'b1;
    run_cmd("R7 ake on", cw(13, 1, 0, 2, 0, 0), 4, img, 16'h4001, exp_words(img));
    ake_en_i = 1'b0;
  endtask

  task automatic t_lengths();
    logic [127:0] img;
    img = mk_img(32'hDEAD_BEEF, 8'h40);
    run_cmd("R5 long short len", cw(2, 2, 0, 1, 0, 0), 15, img, 16'h0080, 0);
    run_cmd("R10 long load", cw(2, 2, 0, 1, 0, 0), 16, img, 16'h0001, exp_words(img));
    run_cmd("R5 short len 3", cw(3, 6, 0, 1, 0, 0), 3, img, 16'h0080, 0);
    run_cmd("R5 none type", cw(4, 0, 0, 0, 0, 0), 0, img, 16'h0001, 0);
    run_cmd("R5 unused type 5", cw(4, 5, 0, 0, 0, 0), 0, img, 16'h0001, 0);
  endtask

  task automatic t_ocr_rca_stop();
    logic [127:0] img;
    img = mk_img(32'h00FF_8000, 8'h50);
    run_cmd("R9 ocr busy", cw(41, 3, 0, 1, 0, 0), 4, img, 16'h1001, exp_words(img));
    img = mk_img(32'h80FF_8000, 8'h51);
    run_cmd("R9 ocr ready", cw(41, 3, 0, 1, 0, 0), 4, img, 16'h0001, exp_words(img));
    img = mk_img(32'h1234_2000, 8'h52);
    run_cmd("R8 rca err", cw(3, 6, 0, 1, 0, 0), 4, img, 16'h4001, exp_words(img));
    img = mk_img(32'h1234_0500, 8'h53);
    run_cmd("R8 rca ok", cw(3, 6, 0, 1, 0, 0), 4, img, 16'h0001, exp_words(img));
    img = mk_img(32'hFFFF_0008, 8'h54);
    run_cmd("R8 rca ake", cw(3, 6, 0, 1, 0, 0), 4, img, 16'h4001, exp_words(img));
    img = mk_img(32'h0, 8'h55);
    run_cmd("R6 stop", cw(12, 1, 1, 2, 0, 0), 4, img, 16'h0005, exp_words(img));
  endtask

  task automatic t_init();
    wr(2'd0, cw(0, 1, 0, 3, 1, 1));
    chk("R3 no launch", 128'(cmd_valid_o), 0);
    chk("R3 status", 128'(status_o), 128'(16'h0001));
    chk("R3 words zeroed", rsp_words_o, 0);
    chk("R3 no flush", 128'(buf_flush_o), 0);
    // still idle: next command accepted
    wr(2'd0, cw(8, 0, 0, 0, 0, 0));
    chk("R3 idle after init", 128'(cmd_valid_o), 1);
    respond(0, 0);
  endtask

  task automatic t_xfer();
    wr(2'd0, cw(18, 1, 0, 3, 1, 0));
    chk("R4 flush", 128'(buf_flush_o), 1);
    chk("R4 active", 128'(xfer_active_o), 1);
    chk("R4 dir", 128'(xfer_dir_o), 1);
    @(negedge clk_i);
    chk("R4 flush pulse", 128'(buf_flush_o), 0);
    respond(4, mk_img(32'h0, 8'h60));
    wr(2'd0, cw(25, 1, 0, 3, 0, 0));
    chk("R4 dir write", 128'(xfer_dir_o), 0);
    respond(4, mk_img(32'h0, 8'h61));
    wr(2'd0, cw(0, 0, 0, 0, 0, 1));
    chk("R3 init keeps xfer", 128'(xfer_active_o), 1);
    wr(2'd0, cw(7, 1, 0, 2, 0, 0));
    chk("R4 other kind ends", 128'(xfer_active_o), 0);
    respond(4, mk_img(32'h0, 8'h62));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    enable_i = 1'b1;
    t_arg_and_launch();
    t_disabled();
    t_pending();
    t_card_err();
    t_lengths();
    t_ocr_rca_stop();
    t_init();
    t_xfer();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule